// File: doc/BRIEF.md
# Hot-Plug Slot Command and Event Registers

This block holds the slot control and slot status words of a hot-plug capable downstream port. Configuration software reaches them through a plain dword-wide access port: a write carries a dword address, four byte enables and 32 data bits, and a read returns the addressed dword one cycle later. Both words share one dword at index `SLOT_DW`. The control word sits in byte lanes 0 and 1, and the status word sits in lanes 2 and 3.

A write that reaches either control byte is treated as one slot command. It stores the new enables and indicator fields. It consumes the self-clearing interlock control bit by flipping the interlock status bit. It always posts the command-completed event, even when no control bit changes value. Slot events from the physical side arrive as single-cycle pulses. The block then raises interrupts in one of two ways. When message-signalled interrupts are on, it emits a one-cycle request pulse. When they are off, it drives a level that follows the enabled pending events.

The access port takes a request every cycle and applies no back-pressure. The MSI request pulse is fire-and-forget: the block waits for no handshake, and the instantiating logic must deliver the message.

Top module: `hp_slot_ctrl`

## Requirements
- R1: A write is a slot command only when `cfg_addr == SLOT_DW` and `cfg_be[1:0]` is not zero. Any other write leaves the control word unchanged, posts no command-completed event and requests no MSI.
- R2: Every slot command sets status bit 4 (command completed) in the same update. This holds also for a spurious command that changes no control bit.
- R3: Control bit 11 (interlock toggle) always reads 0. A command that writes it as 1 through lane 1 inverts status bit 7 (interlock state).
- R4: With MSI on and control bit 5 (hot-plug interrupt enable) set, a command that raises an event enable from 0 to 1 while that event's status is already set gives a one-cycle `msi_req` in the cycle after the write. Repeating the same command gives no further pulse.
- R5: With MSI on and bit 5 set, an event status bit that newly becomes set while its enable is set gives a one-cycle `msi_req` in the next cycle. This covers command completed with enable bit 4.
- R6: `msi_req` never asserts while bit 5 is clear or `msi_enable` is low.
- R7: `intx_level` = !msi_enable AND bit 5 AND the OR over events of (enable AND status). It follows the registers, so it reflects a write from the next cycle on.
- R8: Status event bits are write-1-to-clear through lanes 2 and 3. An event arriving in the same cycle as its clear leaves the bit set.
- R9: After reset, both words read 0, `msi_req` is 0 and `intx_level` is 0.
- R10: `cfg_rd` gives `cfg_rvalid` in the next cycle. `cfg_rdata` is then {status, control} for `SLOT_DW` and zero for every other address.
- R11: Lane 0 writes control bits 7:0 and lane 1 writes bits 15:8. Only bits 0, 1, 3-10 and 12 hold a value. All other control bits read 0.
- R12: The event/enable pairs are: status bit 0 with control bit 0 (attention button), bit 1 with bit 1 (power fault), bit 3 with bit 3 (presence change), bit 4 with bit 4 (command completed), and status bit 8 with control bit 12 (link state change). `hw_evt[0..3]` set status bits 0, 1, 3 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_addr | input | ADDR_W | Dword address |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| hw_evt | input | 4 | Slot event pulses: button, fault, presence, link |
| msi_enable | input | 1 | Message-signalled interrupts in use |
| msi_req | output | 1 | One-cycle MSI request |
| intx_level | output | 1 | Legacy interrupt level |

## Verification
The assertions assume that `msi_enable` holds steady across the cycle in which a write or event is taken. If it changed in that cycle, the registered MSI decision could disagree with the sampled enable. They also assume that reads and writes are never issued in the same cycle. The stimulus changes `msi_enable` only between accesses, on the falling edge, while the access port is idle. It issues every access as a single one-cycle strobe, with hardware events pulsed only in cycles of their own or together with a deliberate clear.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int EV_W = 5;
  // event vector order
  localparam int EV_BTN = 0;
  localparam int EV_FLT = 1;
  localparam int EV_PRS = 2;
  localparam int EV_CC  = 3;
  localparam int EV_LNK = 4;
  // control word bit positions (decoded by software)
  localparam int CB_CCIE = 4;
  localparam int CB_HPIE = 5;
  localparam int CB_EIC  = 11;
  localparam logic [15:0] CTL_KEEP = 16'h17FB;
  // status word bit positions
  localparam int SB_EIS = 7;

  function automatic logic [EV_W-1:0] ctl_enables(input logic [15:0] c);
    return {c[12], c[4], c[3], c[1], c[0]};
  endfunction

  function automatic logic [EV_W-1:0] sts_events(input logic [15:0] s);
    return {s[8], s[4], s[3], s[1], s[0]};
  endfunction

  function automatic logic [15:0] pack_status(input logic [EV_W-1:0] e, input logic eis);
    logic [15:0] s;
    s = '0;
    s[0] = e[EV_BTN];
    s[1] = e[EV_FLT];
    s[3] = e[EV_PRS];
    s[4] = e[EV_CC];
    s[8] = e[EV_LNK];
    s[SB_EIS] = eis;
    return s;
  endfunction
endpackage

// File: rtl/hp_cmd_decode.sv
module hp_cmd_decode
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int SLOT_DW = 6
) (
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  input  logic [15:0]       ctl_q,
  output logic              cmd,
  output logic [15:0]       ctl_d,
  output logic              eis_flip,
  output logic [EV_W-1:0]   clr_ev
);
  logic        hit;
  logic [15:0] merged;
  logic [15:0] sts_w1c;

  assign hit = cfg_wr && (cfg_addr == ADDR_W'(SLOT_DW));
  assign cmd = hit && (|cfg_be[1:0]);

  for (genvar b = 0; b < 2; b++) begin : g_lane
    assign merged[8*b +: 8]  = cfg_be[b]   ? cfg_wdata[8*b +: 8]      : ctl_q[8*b +: 8];
    assign sts_w1c[8*b +: 8] = cfg_be[b+2] ? cfg_wdata[16+8*b +: 8]   : 8'h00;
  end

  assign ctl_d    = cmd ? (merged & CTL_KEEP) : ctl_q;
  assign eis_flip = cmd && cfg_be[1] && cfg_wdata[16'(CB_EIC)];
  assign clr_ev   = hit ? sts_events(sts_w1c) : '0;
endmodule

// File: rtl/hp_status.sv
module hp_status
  import hp_slot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] set_ev,
  input  logic [EV_W-1:0] clr_ev,
  input  logic            eis_flip,
  output logic [EV_W-1:0] ev_q,
  output logic [EV_W-1:0] ev_rise,
  output logic            eis_q
);
  logic [EV_W-1:0] ev_d;

  assign ev_d    = (ev_q & ~clr_ev) | set_ev;
  assign ev_rise = ev_d & ~ev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q  <= '0;
      eis_q <= 1'b0;
    end else begin
      ev_q  <= ev_d;
      eis_q <= eis_q ^ eis_flip;
    end
  end
endmodule

// File: rtl/hp_irq.sv
module hp_irq
  import hp_slot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msi_enable,
  input  logic            cmd,
  input  logic [15:0]     ctl_q,
  input  logic [15:0]     ctl_d,
  input  logic [EV_W-1:0] ev_q,
  input  logic [EV_W-1:0] ev_rise,
  output logic            msi_req,
  output logic            intx_level
);
  logic [EV_W-1:0] en_old, en_new, en_up;
  logic            fire;

  assign en_old = ctl_enables(ctl_q);
  assign en_new = ctl_enables(ctl_d);
  assign en_up  = cmd ? (en_new & ~en_old) : '0;
  assign fire   = msi_enable && ctl_d[CB_HPIE] &&
                  ((|(en_up & ev_q)) || (|(ev_rise & en_new)));

  always_ff @(posedge clk) begin
    if (!rst_n) msi_req <= 1'b0;
    else        msi_req <= fire;
  end

  assign intx_level = !msi_enable && ctl_q[CB_HPIE] && (|(en_old & ev_q));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int SLOT_DW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_rvalid,
  input  logic [3:0]        hw_evt,
  input  logic              msi_enable,
  output logic              msi_req,
  output logic              intx_level
);
  logic [15:0]     ctl_q, ctl_d;
  logic            cmd, eis_flip, eis_q;
  logic [EV_W-1:0] clr_ev, set_ev, ev_q, ev_rise;

  hp_cmd_decode #(.ADDR_W(ADDR_W), .SLOT_DW(SLOT_DW)) u_dec (
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .ctl_q(ctl_q), .cmd(cmd), .ctl_d(ctl_d), .eis_flip(eis_flip), .clr_ev(clr_ev)
  );

  assign set_ev = {hw_evt[3], cmd, hw_evt[2], hw_evt[1], hw_evt[0]};

  hp_status u_sts (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev),
    .eis_flip(eis_flip), .ev_q(ev_q), .ev_rise(ev_rise), .eis_q(eis_q)
  );

  hp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .msi_enable(msi_enable), .cmd(cmd),
    .ctl_q(ctl_q), .ctl_d(ctl_d), .ev_q(ev_q), .ev_rise(ev_rise),
    .msi_req(msi_req), .intx_level(intx_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      ctl_q      <= ctl_d;
      cfg_rvalid <= cfg_rd;
      if (cfg_rd)
        cfg_rdata <= (cfg_addr == ADDR_W'(SLOT_DW)) ? {pack_status(ev_q, eis_q), ctl_q} : 32'h0;
    end
  end
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk #(
  parameter int ADDR_W  = 10,
  parameter int SLOT_DW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_wdata,
  input logic              cfg_rvalid,
  input logic              msi_enable,
  input logic              msi_req,
  input logic              intx_level,
  input logic [15:0]       ctl_q,
  input logic [4:0]        ev_q,
  input logic              eis_q
);
  logic is_cmd;
  assign is_cmd = cfg_wr && (cfg_addr == ADDR_W'(SLOT_DW)) && (|cfg_be[1:0]);

  assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cmd |=> $stable(ctl_q));

  assert_cc_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |=> ev_q[3]);

  assert_eis_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && cfg_be[1] && cfg_wdata[11]) |=> (eis_q != $past(eis_q)));

  assert_msi_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> ($past(msi_enable) && ctl_q[5]));

  assert_intx_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_enable |-> !intx_level);

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rvalid);
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.ADDR_W(ADDR_W), .SLOT_DW(SLOT_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid),
  .msi_enable(msi_enable), .msi_req(msi_req), .intx_level(intx_level),
  .ctl_q(ctl_q), .ev_q(ev_q), .eis_q(eis_q)
);

// File: tb/hp_slot_ctrl_test.sv
module hp_slot_ctrl_test;
  localparam int AW = 10;
  localparam logic [AW-1:0] SLOT = 10'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_rd = 0, msi_enable = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [3:0] cfg_be = '0, hw_evt = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic cfg_rvalid, msi_req, intx_level;
  int n_chk = 0, n_bad = 0;
  logic msi_seen;

  always #2.5 clk = ~clk;

  hp_slot_ctrl #(.ADDR_W(AW), .SLOT_DW(6)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .hw_evt(hw_evt), .msi_enable(msi_enable), .msi_req(msi_req), .intx_level(intx_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d,
                    input logic [3:0] ev = 4'h0);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d; hw_evt = ev;
    @(negedge clk);
    cfg_wr = 0; cfg_be = '0; hw_evt = '0;
    msi_seen = msi_req;
  endtask

  task automatic pulse_evt(input logic [3:0] ev);
    @(negedge clk); hw_evt = ev;
    @(negedge clk); hw_evt = '0;
    msi_seen = msi_req;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_rd = 1; cfg_addr = a;
    @(negedge clk); cfg_rd = 0;
    check("R10 rvalid", {31'd0, cfg_rvalid}, 32'd1);
    d = cfg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R9 msi", {31'd0, msi_req}, 0);
    check("R9 intx", {31'd0, intx_level}, 0);
    rd(SLOT, d); check("R9 regs", d, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(10'd7, 4'hF, 32'hFFFF_FFFF);
    wr(SLOT, 4'hC, 32'h0000_0000);
    rd(SLOT, d); check("R1 no command", d, 0);
    rd(10'd7, d); check("R10 other addr", d, 0);
  endtask

  task automatic t_spurious();
    logic [31:0] d;
    wr(SLOT, 4'h3, 32'h0);
    rd(SLOT, d); check("R2 spurious completes", d, 32'h0010_0000);
    wr(SLOT, 4'hC, 32'h0010_0000);
    rd(SLOT, d); check("R8 w1c", d, 0);
  endtask

  task automatic t_interlock();
    logic [31:0] d;
    wr(SLOT, 4'h3, 32'h0000_0800);
    rd(SLOT, d); check("R3 toggle on", d, 32'h0090_0000);
    wr(SLOT, 4'h3, 32'h0000_0800);
    rd(SLOT, d); check("R3 toggle off", d, 32'h0010_0000);
  endtask

  task automatic t_lanes_intx();
    logic [31:0] d;
    wr(SLOT, 4'h1, 32'h0000_FFFF);
    rd(SLOT, d); check("R11 lane0 only", d, 32'h0010_00FB);
    check("R7 intx from cc", {31'd0, intx_level}, 1);
    @(negedge clk); msi_enable = 1;
    @(negedge clk); check("R7 intx off with msi", {31'd0, intx_level}, 0);
    wr(SLOT, 4'h3, 32'h0);
    check("R6 no msi hpie off", {31'd0, msi_seen}, 0);
  endtask

  task automatic t_msi_rise();
    wr(SLOT, 4'h3, 32'h0000_0030);
    check("R4 enable rise", {31'd0, msi_seen}, 1);
    @(negedge clk); check("R4 single cycle", {31'd0, msi_req}, 0);
    wr(SLOT, 4'h3, 32'h0000_0030);
    check("R4 no repeat", {31'd0, msi_seen}, 0);
  endtask

  task automatic t_msi_new();
    logic [31:0] d;
    wr(SLOT, 4'hC, 32'h0010_0000);
    wr(SLOT, 4'h3, 32'h0000_0030);
    check("R5 cc newly set", {31'd0, msi_seen}, 1);
    wr(SLOT, 4'h3, 32'h0000_0021);
    check("R5 quiet", {31'd0, msi_seen}, 0);
    pulse_evt(4'h1);
    check("R5 button event", {31'd0, msi_seen}, 1);
    rd(SLOT, d); check("R12 button status", d, 32'h0011_0021);
  endtask

  task automatic t_gates();
    wr(SLOT, 4'hF, 32'h011B_0001);
    pulse_evt(4'h1);
    check("R6 hpie clear", {31'd0, msi_seen}, 0);
    @(negedge clk); msi_enable = 0;
    wr(SLOT, 4'h3, 32'h0000_0021);
    check("R6 msi off", {31'd0, msi_seen}, 0);
    check("R7 intx on", {31'd0, intx_level}, 1);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    wr(SLOT, 4'hC, 32'h0001_0000, 4'h1);
    rd(SLOT, d); check("R8 set wins", d, 32'h0011_0021);
    wr(SLOT, 4'hC, 32'h0001_0000);
    check("R7 intx after clear", {31'd0, intx_level}, 0);
  endtask

  task automatic t_link();
    logic [31:0] d;
    wr(SLOT, 4'h3, 32'h0000_1020);
    check("R7 intx idle", {31'd0, intx_level}, 0);
    pulse_evt(4'h8);
    check("R12 link intx", {31'd0, intx_level}, 1);
    rd(SLOT, d); check("R12 link status", d, 32'h0110_1020);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_ignore(); t_spurious(); t_interlock(); t_lanes_intx();
        t_msi_rise(); t_msi_new(); t_gates(); t_setwins(); t_link();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule